// File: doc/BRIEF.md
# Multiplexed Bus Slave Interface

This block is the host-facing register port of a peripheral that sits on a parallel processor bus. The host drives active-low select, read and write strobes, an address latch enable, a 5-bit address and a data bus that is either 8 or 16 bits wide. The block first brings every bus pin into the core clock domain through a two-flop synchroniser. It then holds the address and select together when the latch enable falls. It drives separate output enables for the low and high byte lanes and commits writes to a small word-wide register file.

While the host has the part selected, the block tells the core to stop its clock, and it lets the core run again when the select is released. In narrow mode, a 16-bit register is moved as two byte transfers. An internal lane pointer picks the low byte first and flips after every completed read or write strobe. Reads take priority over writes: if both strobes are asserted together, the cycle is served as a read and the write data is discarded.

Top module: `busif_slave`

## Requirements
- R1: While `ale` is high, the address and the select level used by the block follow the `addr` and `cs_n` pins.
- R2: When `ale` falls, the address and the select level are held. Later changes on `addr` or `cs_n` have no effect until `ale` rises again.
- R3: `oe_lo` is high only while a read is in progress on a selected part. `oe_hi` is high only when `oe_lo` is high and `byte_mode` is low.
- R4: With `byte_mode` high, `oe_hi` stays low and `data_out[15:8]` reads 0. The first read returns the register's bits 7:0 on `data_out[7:0]`, and the next read returns its bits 15:8.
- R5: With `byte_mode` low, a write strobe on a selected part stores all 16 bits of `data_in` into the addressed register when the strobe is released. A later read returns that value.
- R6: With `byte_mode` high, the first write stores `data_in[7:0]` into bits 7:0 of the register, and the second write stores `data_in[7:0]` into bits 15:8.
- R7: If `rd_n` and `wr_n` are low together, the cycle is a read and the addressed register keeps its value. `reg_wr` and `reg_rd` are never high in the same cycle.
- R8: `core_run` is low while the effective select is active and high otherwise.
- R9: After reset, all registers read 0, `oe_lo` and `oe_hi` are low, and `core_run` is high.
- R10: A write strobe while the effective select is inactive leaves the register file unchanged and raises no `reg_wr`.
- R11: Each completed write gives exactly one cycle of `reg_wr`, and each completed read gives exactly one cycle of `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ale | input | 1 | Address latch enable (high = transparent) |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| byte_mode | input | 1 | High selects 8-bit lanes, low selects 16-bit |
| addr | input | 5 | Register address |
| data_in | input | 16 | Bus data toward the block |
| data_out | output | 16 | Bus data from the block |
| oe_lo | output | 1 | Drive enable for data lanes 7:0 |
| oe_hi | output | 1 | Drive enable for data lanes 15:8 |
| core_run | output | 1 | Low halts the core clock |
| reg_wr | output | 1 | One-cycle register write commit |
| reg_rd | output | 1 | One-cycle read completion |
| reg_addr | output | 5 | Address of the current or last access |

## Verification
A read strobe and a write strobe can both be active in the same synchronised cycle. The bench provokes this by pulling `rd_n` and `wr_n` low together on a register that already holds a known value. It then releases the write strobe before the read strobe, so that the write would be committed if reads did not win. The outcome is judged at the ports in three ways: `data_out` shows the old value during the overlap, a later clean read still returns it, and the `reg_wr` pulse count does not move.

// File: rtl/busif_slave.sv
module busif_slave #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              oe_lo,
  output logic              oe_hi,
  output logic              core_run,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [ADDR_W-1:0] reg_addr
);

  localparam int HALF  = DATA_W / 2;
  localparam int DEPTH = 1 << ADDR_W;

  logic [1:0]        ale_q, cs_q, rd_q, wr_q;
  logic [ADDR_W-1:0] addr_q1, addr_q2, addr_lat, xaddr;
  logic [DATA_W-1:0] din_q1, din_q2, wdata;
  logic              sel_lat, rd_pend, wr_pend, wr_kill, lane;
  logic [DATA_W-1:0] mem [DEPTH];

  wire ale_s = ale_q[1];
  wire cs_s  = cs_q[1];
  wire rd_s  = rd_q[1];
  wire wr_s  = wr_q[1];

  wire [ADDR_W-1:0] eff_addr = ale_s ? addr_q2 : addr_lat;
  wire              sel      = ale_s ? ~cs_s : sel_lat;

  wire rd_act  = sel & ~rd_s;
  wire wr_act  = sel & ~wr_s & rd_s & ~wr_kill;
  wire rd_done = rd_pend & rd_s;
  wire wr_done = wr_pend & wr_s;

  wire [DATA_W-1:0] rword = mem[eff_addr];
  wire [HALF-1:0]   rbyte = lane ? rword[DATA_W-1:HALF] : rword[HALF-1:0];

  assign oe_lo    = rd_act;
  assign oe_hi    = rd_act & ~byte_mode;
  assign core_run = ~sel;
  assign reg_wr   = wr_done;
  assign reg_rd   = rd_done;
  assign reg_addr = xaddr;
  assign data_out = !rd_act   ? '0 :
                    byte_mode ? {{HALF{1'b0}}, rbyte} : rword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q   <= 2'b11;
      cs_q    <= 2'b11;
      rd_q    <= 2'b11;
      wr_q    <= 2'b11;
      addr_q1 <= '0;
      addr_q2 <= '0;
      din_q1  <= '0;
      din_q2  <= '0;
    end else begin
      ale_q   <= {ale_q[0], ale};
      cs_q    <= {cs_q[0], cs_n};
      rd_q    <= {rd_q[0], rd_n};
      wr_q    <= {wr_q[0], wr_n};
      addr_q1 <= addr;
      addr_q2 <= addr_q1;
      din_q1  <= data_in;
      din_q2  <= din_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lat <= '0;
      sel_lat  <= 1'b0;
    end else if (ale_s) begin
      addr_lat <= addr_q2;
      sel_lat  <= ~cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      wr_kill <= 1'b0;
      wdata   <= '0;
      xaddr   <= '0;
    end else begin
      if (rd_done)     rd_pend <= 1'b0;
      else if (rd_act) rd_pend <= 1'b1;

      if (wr_s)                 wr_kill <= 1'b0;
      else if (~rd_s)           wr_kill <= 1'b1;

      if (wr_done || rd_act)    wr_pend <= 1'b0;
      else if (wr_act)          wr_pend <= 1'b1;

      if (wr_act)               wdata <= din_q2;
      if (wr_act || rd_act)     xaddr <= eff_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    lane <= 1'b0;
    else if (!byte_mode)           lane <= 1'b0;
    else if (rd_done || wr_done)   lane <= ~lane;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_done) begin
      if (!byte_mode)  mem[xaddr]                <= wdata;
      else if (lane)   mem[xaddr][DATA_W-1:HALF] <= wdata[HALF-1:0];
      else             mem[xaddr][HALF-1:0]      <= wdata[HALF-1:0];
    end
  end

endmodule

// File: rtl/busif_slave_chk.sv
module busif_slave_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_mode,
  input logic [DATA_W-1:0] data_out,
  input logic              oe_lo,
  input logic              oe_hi,
  input logic              core_run,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr
);

  assert_hi_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_hi |-> (oe_lo && !byte_mode));

  assert_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_mode |-> (!oe_hi && data_out[DATA_W-1:DATA_W/2] == '0));

  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    oe_lo |-> !core_run);

  assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!oe_lo && !oe_hi && core_run));

  assert_wr_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> $stable(reg_addr));

endmodule

bind busif_slave busif_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/busif_slave_bench.sv
module busif_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ale = 1'b1, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, byte_mode = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] data_in = '0;
  logic [15:0] data_out;
  logic        oe_lo, oe_hi, core_run, reg_wr, reg_rd;
  logic [4:0]  reg_addr;

  int checks = 0, errors = 0, nwr = 0, nrd = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  busif_slave u_busif_slave (.*);

  always @(posedge clk) begin
    if (reg_wr) nwr++;
    if (reg_rd) nrd++;
  end

  task automatic w(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [4:0] a, logic [15:0] d);
    addr = a; data_in = d; cs_n = 1'b0; w(3);
    wr_n = 1'b0; w(4);
    wr_n = 1'b1; w(4);
    cs_n = 1'b1; w(4);
  endtask

  task automatic bus_read(logic [4:0] a, output logic [15:0] d,
                          output logic ol, output logic oh);
    addr = a; cs_n = 1'b0; w(3);
    rd_n = 1'b0; w(4);
    d = data_out; ol = oe_lo; oh = oe_hi;
    rd_n = 1'b1; w(4);
    cs_n = 1'b1; w(4);
  endtask

  task automatic t_reset;
    logic [15:0] d; logic ol, oh;
    chk("R9 oe_lo", oe_lo, 0);
    chk("R9 oe_hi", oe_hi, 0);
    chk("R9 core_run", core_run, 1);
    bus_read(5'd3, d, ol, oh);
    chk("R9 reg3 zero", d, 16'h0);
  endtask

  task automatic t_word;
    logic [15:0] d; logic ol, oh; int w0, r0;
    w0 = nwr; r0 = nrd;
    bus_write(5'd3, 16'hA5C3);
    bus_write(5'd4, 16'h0F0F);
    bus_read(5'd3, d, ol, oh);
    chk("R5 word data", d, 16'hA5C3);
    chk("R3 oe_lo word", ol, 1);
    chk("R3 oe_hi word", oh, 1);
    chk("R11 write pulses", nwr - w0, 2);
    chk("R11 read pulses", nrd - r0, 1);
    bus_read(5'd4, d, ol, oh);
    chk("R1 transparent addr", d, 16'h0F0F);
    chk("R3 idle oe_lo", oe_lo, 0);
  endtask

  task automatic t_halt;
    cs_n = 1'b0; w(4);
    chk("R8 halted", core_run, 0);
    chk("R3 no read no oe", oe_lo, 0);
    cs_n = 1'b1; w(4);
    chk("R8 resumed", core_run, 1);
  endtask

  task automatic t_latch;
    ale = 1'b1; addr = 5'd4; cs_n = 1'b0; w(4);
    ale = 1'b0; w(4);
    addr = 5'd3; cs_n = 1'b1; w(4);
    rd_n = 1'b0; w(4);
    chk("R2 held addr", data_out, 16'h0F0F);
    chk("R2 held select", oe_lo, 1);
    chk("R8 held halt", core_run, 0);
    rd_n = 1'b1; w(4);
    ale = 1'b1; w(4);
    chk("R1 select follows", core_run, 1);
    addr = 5'd3; cs_n = 1'b1; w(4);
    ale = 1'b0; w(4);
    cs_n = 1'b0; w(4);
    rd_n = 1'b0; w(4);
    chk("R2 held deselect oe", oe_lo, 0);
    chk("R2 held deselect run", core_run, 1);
    rd_n = 1'b1; cs_n = 1'b1; w(4);
    ale = 1'b1; w(4);
  endtask

  task automatic t_byte;
    logic [15:0] d; logic ol, oh;
    byte_mode = 1'b1; w(2);
    bus_write(5'd7, 16'hEE34);
    bus_write(5'd7, 16'hDD12);
    bus_read(5'd7, d, ol, oh);
    chk("R4 first byte", d, 16'h0034);
    chk("R4 oe_hi low", oh, 0);
    chk("R3 oe_lo byte", ol, 1);
    bus_read(5'd7, d, ol, oh);
    chk("R4 second byte", d, 16'h0012);
    byte_mode = 1'b0; w(2);
    bus_read(5'd7, d, ol, oh);
    chk("R6 assembled word", d, 16'h1234);
  endtask

  task automatic t_overlap;
    logic [15:0] d; logic ol, oh; int w0;
    bus_write(5'd5, 16'h1111);
    w0 = nwr;
    addr = 5'd5; data_in = 16'h2222; cs_n = 1'b0; w(3);
    rd_n = 1'b0; wr_n = 1'b0; w(4);
    chk("R7 overlap reads", data_out, 16'h1111);
    chk("R7 overlap oe", oe_lo, 1);
    wr_n = 1'b1; w(4);
    rd_n = 1'b1; w(4);
    cs_n = 1'b1; w(4);
    chk("R7 no commit", nwr - w0, 0);
    bus_read(5'd5, d, ol, oh);
    chk("R7 value kept", d, 16'h1111);
  endtask

  task automatic t_nosel;
    logic [15:0] d; logic ol, oh; int w0;
    w0 = nwr;
    addr = 5'd5; data_in = 16'h3333; w(3);
    wr_n = 1'b0; w(4);
    wr_n = 1'b1; w(4);
    chk("R10 no pulse", nwr - w0, 0);
    bus_read(5'd5, d, ol, oh);
    chk("R10 value kept", d, 16'h1111);
  endtask

  initial begin
    w(3);
    rst_n = 1'b1;
    w(4);
    t_reset();
    t_word();
    t_halt();
    t_latch();
    t_byte();
    t_overlap();
    t_nosel();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule